// File: doc/BRIEF.md
# Accumulator ALU with Flag Registers

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it may receive a 5-bit operation code together with the value of the selected operand register and the current accumulator value. One clock edge later it presents the 8-bit result and a one-cycle accumulator write strobe, and it updates the zero and carry flags that it holds. The surrounding machine copies the result into the accumulator whenever the strobe is high. Every operation that writes back targets the accumulator, whichever register supplied the operand. The operand register itself is never written.

The block implements add and subtract with carry, increment, decrement, NOT, AND, OR and XOR, shift through carry, rotate, and compare. It also accepts two commands that force the carry flag. Each operation changes only its own fixed set of flags. Compare sets the flags but does not write the accumulator. The shift operations use the stored carry as the bit that fills the vacated position.

Top module: `acc_flag_alu`

## Requirements
- R1: While `rstN` is low, and after it returns high until the first accepted operation, `resultOut`, `accWrEn`, `zeroFlag` and `carryFlag` are all 0.
- R2: An operation presented with `opValid` high affects the outputs on the next rising edge. When `opValid` is low, `accWrEn` is 0 after that edge and `resultOut`, `zeroFlag` and `carryFlag` keep their values.
- R3: Code 00010 (add with carry) writes (operand + accumulator + carry) mod 256 to the accumulator. Carry becomes 1 exactly when the 9-bit sum exceeds 255.
- R4: Code 00011 (increment) writes operand + 1, and carry is the carry-out. Code 00101 (decrement) writes operand − 1, and carry is the borrow-out, which is 1 only when the operand is 0.
- R5: Code 00100 (subtract with carry) writes (operand − accumulator − carry) mod 256. Carry becomes the borrow, which is 1 exactly when the true difference is negative.
- R6: Codes 00110 (NOT operand), 00111 (XOR), 01000 (AND) and 01001 (OR) write their bitwise result and leave carry unchanged.
- R7: Code 01010 shifts the operand left, with the old carry entering bit 0 and the old bit 7 going to carry. Code 01011 shifts right, with the old carry entering bit 7 and the old bit 0 going to carry.
- R8: Code 01100 rotates left (bit 7 to bit 0 and to carry). Code 01101 rotates right (bit 0 to bit 7 and to carry).
- R9: Code 01110 (compare) does not write: `accWrEn` stays 0 and `resultOut` holds. Zero is set when the accumulator equals the operand. Carry is set when the accumulator is greater than the operand.
- R10: After every operation that writes, `zeroFlag` is 1 exactly when `resultOut` is 0.
- R11: Code 11100 sets carry and code 11101 clears carry. Neither command writes the accumulator or changes zero.
- R12: Every other code is ignored: no write, and the result and both flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 5 | Operation code |
| operandVal | input | 8 | Value of the selected operand register |
| accVal | input | 8 | Current accumulator value |
| resultOut | output | 8 | Registered result destined for the accumulator |
| accWrEn | output | 1 | One-cycle accumulator write strobe |
| zeroFlag | output | 1 | Stored zero flag |
| carryFlag | output | 1 | Stored carry flag, also the carry input to the next operation |

## Verification
The hardest situations to reach are those where the stored carry decides the outcome. Examples are a subtract with carry whose operand equals the accumulator plus one, which gives a zero result without a borrow, and a right shift whose bit 7 comes from a carry left by an earlier operation. Because the carry cannot be loaded directly, the directed tasks first run a set-carry or clear-carry command, or an add that overflows, and then issue the operation under test. This exercises both carry-in values for each code. A random sweep follows over all codes with random operands, and a model in the bench tracks the carry from one operation to the next.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 5;

  // operation codes
  localparam logic [OP_W-1:0] OPC_ADC  = 5'b00010;
  localparam logic [OP_W-1:0] OPC_INC  = 5'b00011;
  localparam logic [OP_W-1:0] OPC_SBC  = 5'b00100;
  localparam logic [OP_W-1:0] OPC_DEC  = 5'b00101;
  localparam logic [OP_W-1:0] OPC_NOT  = 5'b00110;
  localparam logic [OP_W-1:0] OPC_XOR  = 5'b00111;
  localparam logic [OP_W-1:0] OPC_AND  = 5'b01000;
  localparam logic [OP_W-1:0] OPC_OR   = 5'b01001;
  localparam logic [OP_W-1:0] OPC_SHL  = 5'b01010;
  localparam logic [OP_W-1:0] OPC_SHR  = 5'b01011;
  localparam logic [OP_W-1:0] OPC_ROL  = 5'b01100;
  localparam logic [OP_W-1:0] OPC_ROR  = 5'b01101;
  localparam logic [OP_W-1:0] OPC_CMP  = 5'b01110;
  localparam logic [OP_W-1:0] OPC_SETC = 5'b11100;
  localparam logic [OP_W-1:0] OPC_CLRC = 5'b11101;

  typedef enum logic [3:0] {
    FN_NONE, FN_ADD, FN_INC, FN_SUB, FN_DEC, FN_NOT, FN_XOR, FN_AND,
    FN_OR, FN_SHL, FN_SHR, FN_ROL, FN_ROR, FN_CMP
  } aluFunc_e;

  typedef struct packed {
    aluFunc_e func;
    logic     writeAcc;
    logic     updZero;
    logic     updCarry;
    logic     forceCarry;
    logic     forceVal;
  } aluStrobe_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strb
);

  always_comb begin
    strb = '{func: FN_NONE, writeAcc: 1'b0, updZero: 1'b0, updCarry: 1'b0,
             forceCarry: 1'b0, forceVal: 1'b0};
    if (opValid) begin
      case (opCode)
        OPC_ADC: strb.func = FN_ADD;
        OPC_INC: strb.func = FN_INC;
        OPC_SBC: strb.func = FN_SUB;
        OPC_DEC: strb.func = FN_DEC;
        OPC_NOT: strb.func = FN_NOT;
        OPC_XOR: strb.func = FN_XOR;
        OPC_AND: strb.func = FN_AND;
        OPC_OR:  strb.func = FN_OR;
        OPC_SHL: strb.func = FN_SHL;
        OPC_SHR: strb.func = FN_SHR;
        OPC_ROL: strb.func = FN_ROL;
        OPC_ROR: strb.func = FN_ROR;
        OPC_CMP: strb.func = FN_CMP;
        OPC_SETC: begin
          strb.forceCarry = 1'b1;
          strb.forceVal   = 1'b1;
        end
        OPC_CLRC: begin
          strb.forceCarry = 1'b1;
          strb.forceVal   = 1'b0;
        end
        default: strb.func = FN_NONE;
      endcase

      case (strb.func)
        FN_NONE: ;
        FN_CMP: begin
          strb.updZero  = 1'b1;
          strb.updCarry = 1'b1;
        end
        FN_NOT, FN_XOR, FN_AND, FN_OR: begin
          strb.writeAcc = 1'b1;
          strb.updZero  = 1'b1;
        end
        default: begin
          strb.writeAcc = 1'b1;
          strb.updZero  = 1'b1;
          strb.updCarry = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strb,
  input  logic [DATA_W-1:0] operandVal,
  input  logic [DATA_W-1:0] accVal,
  output logic [DATA_W-1:0] resultOut,
  output logic              accWrEn,
  output logic              zeroFlag,
  output logic              carryFlag
);

  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0]  opExt, accExt, cinExt, oneExt, wideRes;
  logic [DATA_W-1:0] nextRes;
  logic              nextCarry, nextZero;

  assign opExt  = {1'b0, operandVal};
  assign accExt = {1'b0, accVal};
  assign cinExt = {{DATA_W{1'b0}}, carryFlag};
  assign oneExt = {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    wideRes   = '0;
    nextRes   = '0;
    nextCarry = carryFlag;
    case (strb.func)
      FN_ADD: begin
        wideRes   = opExt + accExt + cinExt;
        nextRes   = wideRes[DATA_W-1:0];
        nextCarry = wideRes[DATA_W];
      end
      FN_INC: begin
        wideRes   = opExt + oneExt;
        nextRes   = wideRes[DATA_W-1:0];
        nextCarry = wideRes[DATA_W];
      end
      FN_SUB: begin
        wideRes   = opExt - accExt - cinExt;
        nextRes   = wideRes[DATA_W-1:0];
        nextCarry = wideRes[DATA_W];
      end
      FN_DEC: begin
        wideRes   = opExt - oneExt;
        nextRes   = wideRes[DATA_W-1:0];
        nextCarry = wideRes[DATA_W];
      end
      FN_NOT: nextRes = ~operandVal;
      FN_XOR: nextRes = operandVal ^ accVal;
      FN_AND: nextRes = operandVal & accVal;
      FN_OR:  nextRes = operandVal | accVal;
      FN_SHL: begin
        nextRes   = {operandVal[DATA_W-2:0], carryFlag};
        nextCarry = operandVal[DATA_W-1];
      end
      FN_SHR: begin
        nextRes   = {carryFlag, operandVal[DATA_W-1:1]};
        nextCarry = operandVal[0];
      end
      FN_ROL: begin
        nextRes   = {operandVal[DATA_W-2:0], operandVal[DATA_W-1]};
        nextCarry = operandVal[DATA_W-1];
      end
      FN_ROR: begin
        nextRes   = {operandVal[0], operandVal[DATA_W-1:1]};
        nextCarry = operandVal[0];
      end
      FN_CMP: begin
        wideRes   = accExt - opExt;
        nextRes   = wideRes[DATA_W-1:0];
        nextCarry = ~wideRes[DATA_W] & (nextRes != '0);
      end
      default: ;
    endcase
    nextZero = (nextRes == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut <= '0;
      accWrEn   <= 1'b0;
      zeroFlag  <= 1'b0;
      carryFlag <= 1'b0;
    end else begin
      accWrEn <= strb.writeAcc;
      if (strb.writeAcc) resultOut <= nextRes;
      if (strb.updZero) zeroFlag <= nextZero;
      if (strb.forceCarry) carryFlag <= strb.forceVal;
      else if (strb.updCarry) carryFlag <= nextCarry;
    end
  end

endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operandVal,
  input  logic [DATA_W-1:0] accVal,
  output logic [DATA_W-1:0] resultOut,
  output logic              accWrEn,
  output logic              zeroFlag,
  output logic              carryFlag
);

  aluStrobe_t strb;

  acc_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strb    (strb)
  );

  acc_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .operandVal (operandVal),
    .accVal     (accVal),
    .resultOut  (resultOut),
    .accWrEn    (accWrEn),
    .zeroFlag   (zeroFlag),
    .carryFlag  (carryFlag)
  );

endmodule

// File: rtl/acc_flag_alu_chk.sv
module acc_flag_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opCode,
  input logic [DATA_W-1:0] operandVal,
  input logic [DATA_W-1:0] accVal,
  input logic [DATA_W-1:0] resultOut,
  input logic              accWrEn,
  input logic              zeroFlag,
  input logic              carryFlag
);

  logic isLogicOp;
  assign isLogicOp = (opCode == OPC_NOT) || (opCode == OPC_XOR) ||
                     (opCode == OPC_AND) || (opCode == OPC_OR);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !accWrEn && $stable(resultOut) && $stable(zeroFlag) && $stable(carryFlag));

  a_r6_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rstN)
    opValid && isLogicOp |=> accWrEn && $stable(carryFlag));

  a_r7_shl_carry_out: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OPC_SHL |=> carryFlag == $past(operandVal[DATA_W-1]));

  a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OPC_CMP |=> !accWrEn && $stable(resultOut));

  a_r10_zero_matches: assert property (@(posedge clk) disable iff (!rstN)
    accWrEn |-> zeroFlag == (resultOut == '0));

  a_r11_set_carry: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OPC_SETC |=> carryFlag && !accWrEn && $stable(zeroFlag));

  a_r11_clr_carry: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == OPC_CLRC |=> !carryFlag && !accWrEn && $stable(zeroFlag));

endmodule

bind acc_flag_alu acc_flag_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/acc_flag_alu_tb.sv
module acc_flag_alu_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] operandVal = '0;
  logic [7:0] accVal = '0;
  logic [7:0] resultOut;
  logic       accWrEn, zeroFlag, carryFlag;

  int nVec = 0;
  int nBad = 0;
  int cyc = 0;

  // bench model state
  logic [7:0] mRes = '0;
  logic       mZ = 1'b0;
  logic       mC = 1'b0;

  always #5 clk = ~clk;

  acc_flag_alu u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .operandVal(operandVal), .accVal(accVal), .resultOut(resultOut),
    .accWrEn(accWrEn), .zeroFlag(zeroFlag), .carryFlag(carryFlag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nBad = nBad + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic compare(input string tag, input logic [7:0] r, input logic we,
                         input logic z, input logic c);
    nVec = nVec + 1;
    if ({resultOut, accWrEn, zeroFlag, carryFlag} !== {r, we, z, c}) begin
      nBad = nBad + 1;
      $display("FAIL %s: actual res=%02h we=%b z=%b c=%b expected res=%02h we=%b z=%b c=%b",
               tag, resultOut, accWrEn, zeroFlag, carryFlag, r, we, z, c);
    end
  endtask

  // drive one operation, compute expected from the requirements, check after the edge
  task automatic applyOp(input string tag, input logic [4:0] op,
                         input logic [7:0] o, input logic [7:0] a);
    int s;
    logic [7:0] r;
    logic wr, nz, nc;
    r = mRes; wr = 1'b0; nz = mZ; nc = mC;
    case (op)
      5'b00010: begin s = int'(o) + int'(a) + int'(mC); r = 8'(s); nc = (s > 255); wr = 1; end
      5'b00011: begin s = int'(o) + 1; r = 8'(s); nc = (s > 255); wr = 1; end
      5'b00100: begin s = int'(o) - int'(a) - int'(mC); r = 8'(s & 255); nc = (s < 0); wr = 1; end
      5'b00101: begin s = int'(o) - 1; r = 8'(s & 255); nc = (s < 0); wr = 1; end
      5'b00110: begin r = 8'(255 - int'(o)); wr = 1; end
      5'b00111: begin r = o ^ a; wr = 1; end
      5'b01000: begin r = o & a; wr = 1; end
      5'b01001: begin r = o | a; wr = 1; end
      5'b01010: begin r = 8'((int'(o) * 2) % 256 + int'(mC)); nc = (o >= 8'd128); wr = 1; end
      5'b01011: begin r = 8'(int'(o) / 2 + (mC ? 128 : 0)); nc = (o % 2 == 1); wr = 1; end
      5'b01100: begin r = 8'((int'(o) * 2) % 256 + (o >= 8'd128 ? 1 : 0)); nc = (o >= 8'd128); wr = 1; end
      5'b01101: begin r = 8'(int'(o) / 2 + ((o % 2 == 1) ? 128 : 0)); nc = (o % 2 == 1); wr = 1; end
      5'b01110: begin nz = (a == o); nc = (a > o); end
      5'b11100: nc = 1'b1;
      5'b11101: nc = 1'b0;
      default: ;
    endcase
    if (wr) nz = (r == 8'd0);
    @(negedge clk);
    opValid = 1'b1; opCode = op; operandVal = o; accVal = a;
    @(posedge clk);
    #1;
    compare(tag, r, wr, nz, nc);
    mRes = r; mZ = nz; mC = nc;
    @(negedge clk);
    opValid = 1'b0;
    operandVal = 8'hA5; accVal = 8'h5A; opCode = 5'b01001;
  endtask

  task automatic tIdle();
    @(negedge clk);
    opValid = 1'b0; opCode = 5'b00110; operandVal = 8'h00;
    @(posedge clk);
    #1;
    compare("R2 idle hold", mRes, 1'b0, mZ, mC);
  endtask

  task automatic tReset();
    @(negedge clk);
    rstN = 1'b0; opValid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    compare("R1 in reset", 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    compare("R1 after release", 8'h00, 1'b0, 1'b0, 1'b0);
    mRes = '0; mZ = 1'b0; mC = 1'b0;
  endtask

  task automatic tAdd();
    applyOp("R11 clear", 5'b11101, 8'h00, 8'h00);
    applyOp("R3 add no carry", 5'b00010, 8'h12, 8'h34);
    applyOp("R3 add overflow to zero", 5'b00010, 8'hFF, 8'h01);
    applyOp("R3 add uses carry in", 5'b00010, 8'h10, 8'h20);
    applyOp("R3 add carry in to overflow", 5'b00010, 8'hFF, 8'h00);
    tIdle();
  endtask

  task automatic tIncDec();
    applyOp("R4 inc", 5'b00011, 8'h41, 8'h00);
    applyOp("R4 inc wrap", 5'b00011, 8'hFF, 8'h33);
    applyOp("R4 dec", 5'b00101, 8'h01, 8'h00);
    applyOp("R4 dec borrow", 5'b00101, 8'h00, 8'h00);
  endtask

  task automatic tSub();
    applyOp("R11 clear", 5'b11101, 8'h00, 8'h00);
    applyOp("R5 sub no borrow", 5'b00100, 8'h50, 8'h20);
    applyOp("R5 sub borrow", 5'b00100, 8'h20, 8'h50);
    applyOp("R5 sub carry in exact zero", 5'b00100, 8'h51, 8'h50);
    applyOp("R11 set", 5'b11100, 8'h00, 8'h00);
    applyOp("R5 sub carry in borrow", 5'b00100, 8'h50, 8'h50);
  endtask

  task automatic tLogic();
    applyOp("R11 set", 5'b11100, 8'h00, 8'h00);
    applyOp("R6 not keeps carry", 5'b00110, 8'h0F, 8'hAA);
    applyOp("R6 xor zero", 5'b00111, 8'h3C, 8'h3C);
    applyOp("R11 clear", 5'b11101, 8'h00, 8'h00);
    applyOp("R6 and", 5'b01000, 8'hF0, 8'h3C);
    applyOp("R6 or", 5'b01001, 8'h81, 8'h18);
  endtask

  task automatic tShift();
    applyOp("R11 set", 5'b11100, 8'h00, 8'h00);
    applyOp("R7 shl carry fill", 5'b01010, 8'h80, 8'h00);
    applyOp("R7 shl after carry out", 5'b01010, 8'h00, 8'h00);
    applyOp("R11 set", 5'b11100, 8'h00, 8'h00);
    applyOp("R7 shr carry to bit7", 5'b01011, 8'h02, 8'h00);
    applyOp("R7 shr bit0 out zero", 5'b01011, 8'h01, 8'h00);
  endtask

  task automatic tRotate();
    applyOp("R8 rol", 5'b01100, 8'h81, 8'h00);
    applyOp("R8 rol no msb", 5'b01100, 8'h40, 8'h00);
    applyOp("R8 ror", 5'b01101, 8'h01, 8'h00);
    applyOp("R8 ror even", 5'b01101, 8'h00, 8'hFF);
  endtask

  task automatic tCompare();
    applyOp("R3 add seed", 5'b00010, 8'h07, 8'h00);
    applyOp("R9 cmp equal", 5'b01110, 8'h44, 8'h44);
    applyOp("R9 cmp acc greater", 5'b01110, 8'h10, 8'h90);
    applyOp("R9 cmp acc less", 5'b01110, 8'h90, 8'h10);
  endtask

  task automatic tCarryCmds();
    applyOp("R6 xor zero", 5'b00111, 8'h55, 8'h55);
    applyOp("R11 set keeps zero", 5'b11100, 8'h12, 8'h34);
    applyOp("R11 clear keeps zero", 5'b11101, 8'h12, 8'h34);
  endtask

  task automatic tUnused();
    applyOp("R11 set", 5'b11100, 8'h00, 8'h00);
    applyOp("R12 unused 00000", 5'b00000, 8'h00, 8'h00);
    applyOp("R12 unused 00001", 5'b00001, 8'hFF, 8'hFF);
    applyOp("R12 unused 01111", 5'b01111, 8'h00, 8'h01);
    applyOp("R12 unused 11111", 5'b11111, 8'h80, 8'h80);
    tIdle();
  endtask

  task automatic tRandomSweep();
    for (int k = 0; k < 1500; k++) begin
      logic [4:0] op;
      op = 5'(2 + ($urandom % 15));
      if (op == 5'd15) op = 5'b11100;
      if (op == 5'd16) op = 5'b11101;
      applyOp("R10 random sweep", op, 8'($urandom), 8'($urandom));
    end
  endtask

  initial begin
    tReset();
    tAdd();
    tIncDec();
    tSub();
    tLogic();
    tShift();
    tRotate();
    tCompare();
    tCarryCmds();
    tUnused();
    tRandomSweep();
    tReset();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule